// File: doc/BRIEF.md
# Programmable Peripheral Clock-Enable Path

This block produces the clock enable for one peripheral. It selects one of four source enable pulses, divides that pulse train through two cascaded programmable divide stages, chooses between the divided train and a crystal-rate bypass pulse, and passes the result through a disable gate. Every source and the output are single-cycle enable pulses on one fast reference clock, so the whole path is ordinary synchronous logic.

Software controls the path through six 32-bit registers on a valid/ready port: a source register, three divider registers, a path-select register and a disable register. Only the first divider register feeds this channel; the other two are plain storage that the restore sequence also carries. A save strobe copies all six registers into shadow storage. A restore strobe writes them back one per cycle in a fixed order that applies the disable first and the path select last.

Top module: `periph_clk_path`

## Requirements
- R1: After reset the registers read source 0x0, divider-0 0x9, divider-1 0x0, divider-2 0x0, path-select 0x1, disable 0x0, and both `clk_en_o` and `div_err_o` are 0.
- R2: The register word at byte address A is index A/4: source 0, divider-0 1, divider-1 2, divider-2 3, path-select 4, disable 5. An accepted read returns its data with `rsp_valid` high exactly one cycle later. A write gives no response. Indexes 6 and 7 and addresses with bits [1:0] not zero read as 0 and ignore writes.
- R3: Bits [1:0] of the source register select which bit of `src_pulse` drives the divider chain. Pulses on the other bits have no effect.
- R4: Bits [2:0] of divider-0 set the first stage divisor and bits [5:3] set the second. Codes 1 to 6 divide by their value. With a continuous source the output period is the product of the two divisors.
- R5: A code of 0 or 7 in either stage field is a zero divide. No divided output pulse is produced while it is programmed, and `div_err_o` rises and stays high until reset, even after the code is made valid again.
- R6: Bit 0 of the disable register, when 1, holds `clk_en_o` at 0. When it is 0 the pulses pass. The other bits of that register do not gate.
- R7: Bit 0 of the path-select register picks the divided train (1) or `xtal_pulse` (0). The unselected input has no effect on `clk_en_o`.
- R8: A rewritten divider code takes effect only at that stage's next terminal count. The period in progress finishes with the old divisor.
- R9: A restore keeps `req_ready` low for exactly six cycles. It rewrites the saved values in the order disable, divider-0, divider-1, divider-2, source, path-select, and afterwards every register reads back its saved value.
- R10: `clk_en_o` is high in the cycle after the clock edge that samples a qualifying input pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | NUM_SRC | Source enable pulses |
| xtal_pulse | input | 1 | Bypass enable pulse |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register port can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| save_req | input | 1 | Copy registers into shadow storage |
| restore_req | input | 1 | Start the ordered rewrite from shadow storage |
| clk_en_o | output | 1 | Output enable pulse |
| div_err_o | output | 1 | Sticky zero-divide flag |

## Verification
The hardest case to reach is a divider rewrite that lands in the middle of a count. The bench first locks onto an output pulse so that it knows the counter phase. It then issues the write a known number of cycles later and measures the next two gaps, which should be the remainder of the old period and then a full new period. The restore order is reached by moving the path into bypass with the gate open, so that every cycle produces a pulse. The bench then counts the pulses that still appear while the port is busy. Only an early rewrite of the disable register keeps that count at two.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 6;
    localparam int CODE_W   = 3;
    localparam int MAX_DIV  = 6;

    typedef enum logic [2:0] {
        IDX_SRC  = 3'd0,
        IDX_DIV0 = 3'd1,
        IDX_DIV1 = 3'd2,
        IDX_DIV2 = 3'd3,
        IDX_CSEL = 3'd4,
        IDX_DIS  = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic pulse;
        logic bad;
    } stage_out_t;

    // Register written at each restore step; disable goes first, path select last.
    function automatic reg_idx_e restore_slot(input logic [2:0] step);
        case (step)
            3'd0:    return IDX_DIS;
            3'd1:    return IDX_DIV0;
            3'd2:    return IDX_DIV1;
            3'd3:    return IDX_DIV2;
            3'd4:    return IDX_SRC;
            default: return IDX_CSEL;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_reset(input reg_idx_e idx);
        case (idx)
            IDX_DIV0: return 32'h0000_0009;
            IDX_CSEL: return 32'h0000_0001;
            default:  return '0;
        endcase
    endfunction

    function automatic logic code_usable(input logic [CODE_W-1:0] code);
        return (code != '0) && (int'(code) <= MAX_DIV);
    endfunction
endpackage

// File: rtl/pcp_div_stage.sv
module pcp_div_stage
    import pcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_pulse,
    input  logic [CODE_W-1:0] code,
    output stage_out_t        out_o
);
    logic [CODE_W-1:0] act_q;
    logic [CODE_W-1:0] cnt_q;
    logic prog_bad;
    logic act_ok;
    logic term;

    always_comb begin
        prog_bad = !code_usable(code);
        act_ok   = code_usable(act_q);
        term     = (cnt_q == act_q - CODE_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
        end else if (prog_bad || !act_ok) begin
            act_q <= code;
            cnt_q <= '0;
        end else if (in_pulse) begin
            if (term) begin
                cnt_q <= '0;
                act_q <= code;
            end else begin
                cnt_q <= cnt_q + CODE_W'(1);
            end
        end
    end

    assign out_o.pulse = in_pulse && !prog_bad && act_ok && term;
    assign out_o.bad   = prog_bad;
endmodule

// File: rtl/pcp_out_gate.sv
module pcp_out_gate (
    input  logic clk,
    input  logic rst,
    input  logic div_pulse,
    input  logic xtal_pulse,
    input  logic use_div,
    input  logic gated_off,
    input  logic bad_any,
    output logic clk_en_o,
    output logic err_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_en_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            clk_en_o <= (use_div ? div_pulse : xtal_pulse) && !gated_off;
            err_o    <= err_o || bad_any;
        end
    end
endmodule

// File: rtl/pcp_regfile.sv
module pcp_regfile
    import pcp_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int SEL_W      = 2,
    parameter int STAGE_BITS = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    input  logic                  save_req,
    input  logic                  restore_req,
    output logic [SEL_W-1:0]      sel_o,
    output logic [STAGE_BITS-1:0] codes_o,
    output logic                  use_div_o,
    output logic                  gated_off_o,
    output logic                  busy_o,
    output logic [2:0]            step_o
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [2:0] LAST_STEP = 3'(NUM_REGS - 1);

    logic [NUM_REGS-1:0][DATA_W-1:0] live_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] shadow_q;
    logic                            busy_q;
    logic [2:0]                      step_q;
    logic [IDX_W-1:0]                idx;
    logic                            hit;
    logic                            accept;
    logic [2:0]                      slot;

    always_comb begin
        idx    = req_addr[ADDR_W-1:2];
        hit    = (req_addr[1:0] == 2'b00) && (int'(idx) < NUM_REGS);
        accept = req_valid && !busy_q;
        slot   = restore_slot(step_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                live_q[i]   <= reg_reset(reg_idx_e'(i));
                shadow_q[i] <= reg_reset(reg_idx_e'(i));
            end
            busy_q    <= 1'b0;
            step_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept && !req_write;
            if (accept && !req_write) begin
                rsp_rdata <= hit ? live_q[idx] : '0;
            end
            if (busy_q) begin
                live_q[slot] <= shadow_q[slot];
                if (step_q == LAST_STEP) begin
                    busy_q <= 1'b0;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 3'd1;
                end
            end else begin
                if (accept && req_write && hit) begin
                    live_q[idx] <= req_wdata;
                end
                if (save_req) begin
                    shadow_q <= live_q;
                end else if (restore_req) begin
                    busy_q <= 1'b1;
                    step_q <= '0;
                end
            end
        end
    end

    assign req_ready   = !busy_q;
    assign sel_o       = live_q[IDX_SRC][SEL_W-1:0];
    assign codes_o     = live_q[IDX_DIV0][STAGE_BITS-1:0];
    assign use_div_o   = live_q[IDX_CSEL][0];
    assign gated_off_o = live_q[IDX_DIS][0];
    assign busy_o      = busy_q;
    assign step_o      = step_q;
endmodule

// File: rtl/periph_clk_path.sv
module periph_clk_path
    import pcp_pkg::*;
#(
    parameter int NUM_SRC    = 4,
    parameter int ADDR_W     = 5,
    parameter int NUM_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_pulse,
    input  logic               xtal_pulse,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic               save_req,
    input  logic               restore_req,
    output logic               clk_en_o,
    output logic               div_err_o
);
    localparam int SEL_W      = $clog2(NUM_SRC);
    localparam int STAGE_BITS = NUM_STAGES * CODE_W;

    logic [SEL_W-1:0]      src_sel;
    logic [STAGE_BITS-1:0] codes;
    logic                  csel_bit;
    logic                  dis_bit;
    logic                  rf_busy;
    logic [2:0]            rf_step;
    logic [NUM_STAGES:0]   chain;
    stage_out_t            st [NUM_STAGES];
    logic                  bad_any;

    pcp_regfile #(
        .ADDR_W    (ADDR_W),
        .SEL_W     (SEL_W),
        .STAGE_BITS(STAGE_BITS)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .save_req   (save_req),
        .restore_req(restore_req),
        .sel_o      (src_sel),
        .codes_o    (codes),
        .use_div_o  (csel_bit),
        .gated_off_o(dis_bit),
        .busy_o     (rf_busy),
        .step_o     (rf_step)
    );

    assign chain[0] = src_pulse[src_sel];

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        pcp_div_stage u_stage (
            .clk     (clk),
            .rst     (rst),
            .in_pulse(chain[g]),
            .code    (codes[g*CODE_W +: CODE_W]),
            .out_o   (st[g])
        );
        assign chain[g+1] = st[g].pulse;
    end

    always_comb begin
        bad_any = 1'b0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            bad_any = bad_any || st[i].bad;
        end
    end

    pcp_out_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .div_pulse (chain[NUM_STAGES]),
        .xtal_pulse(xtal_pulse),
        .use_div   (csel_bit),
        .gated_off (dis_bit),
        .bad_any   (bad_any),
        .clk_en_o  (clk_en_o),
        .err_o     (div_err_o)
    );
endmodule

// File: rtl/pcp_chk.sv
module pcp_chk #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_write,
    input logic               rsp_valid,
    input logic               clk_en_o,
    input logic               div_err_o,
    input logic               dis_bit,
    input logic               csel_bit,
    input logic [NUM_SRC-1:0] src_pulse,
    input logic               xtal_pulse,
    input logic               bad_any,
    input logic               busy,
    input logic [2:0]         step
);
    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        dis_bit |=> !clk_en_o);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        div_err_o |=> div_err_o);

    // R5
    bad_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_any && csel_bit) |=> !clk_en_o);

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    // R9
    restore_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (step == $past(step) + 3'd1));

    // R10
    out_source_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en_o |-> $past(csel_bit ? (|src_pulse) : xtal_pulse));
endmodule

bind periph_clk_path pcp_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .clk_en_o  (clk_en_o),
    .div_err_o (div_err_o),
    .dis_bit   (dis_bit),
    .csel_bit  (csel_bit),
    .src_pulse (src_pulse),
    .xtal_pulse(xtal_pulse),
    .bad_any   (bad_any),
    .busy      (rf_busy),
    .step      (rf_step)
);

// File: tb/periph_clk_path_tb.sv
module periph_clk_path_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  src_pulse = '0;
    logic        xtal_pulse = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        save_req = 1'b0;
    logic        restore_req = 1'b0;
    logic        clk_en_o;
    logic        div_err_o;

    int n_chk = 0;
    int n_bad = 0;

    periph_clk_path u_dut (
        .clk        (clk),
        .rst        (rst),
        .src_pulse  (src_pulse),
        .xtal_pulse (xtal_pulse),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .save_req   (save_req),
        .restore_req(restore_req),
        .clk_en_o   (clk_en_o),
        .div_err_o  (div_err_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        src_pulse = '0;
        xtal_pulse = 1'b0;
        req_valid = 1'b0;
        req_write = 1'b0;
        save_req = 1'b0;
        restore_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_wr(input logic [4:0] addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = addr;
        req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] addr, output logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, "R2 read response one cycle later", rsp_valid, 1);
        data = rsp_rdata;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!clk_en_o && n < 300);
        if (!clk_en_o) n = -1;
    endtask

    task automatic count_pulses(input int cycles, output int c);
        c = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (clk_en_o) c++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] exp_v [6] = '{32'h0, 32'h9, 32'h0, 32'h0, 32'h1, 32'h0};
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        check(clk_en_o == 1'b0, "R1 output idle after reset", clk_en_o, 0);
        check(div_err_o == 1'b0, "R1 error flag clear after reset", div_err_o, 0);
        for (int i = 0; i < 6; i++) begin
            bus_rd(5'(i * 4), d);
            check(d == exp_v[i], "R1 reset register value", d, exp_v[i]);
        end
    endtask

    task automatic t_bus();
        logic [31:0] d;
        do_reset();
        bus_wr(5'h08, 32'h1234_5678);
        check(rsp_valid == 1'b0, "R2 write gives no response", rsp_valid, 0);
        bus_rd(5'h08, d);
        check(d == 32'h1234_5678, "R2 write then read back", d, 32'h1234_5678);
        bus_wr(5'h18, 32'hFFFF_FFFF);
        bus_rd(5'h18, d);
        check(d == 32'h0, "R2 unmapped index reads zero", d, 0);
        bus_wr(5'h09, 32'hDEAD_BEEF);
        bus_rd(5'h08, d);
        check(d == 32'h1234_5678, "R2 misaligned write ignored", d, 32'h1234_5678);
    endtask

    task automatic t_select();
        int c;
        do_reset();
        bus_wr(5'h00, 32'h2);
        src_pulse = 4'b1011;
        count_pulses(20, c);
        check(c == 0, "R3 unselected sources ignored", c, 0);
        src_pulse = 4'b0000;
        @(negedge clk);
        src_pulse = 4'b0100;
        @(negedge clk);
        src_pulse = 4'b0000;
        check(clk_en_o == 1'b1, "R10 output one cycle after selected pulse", clk_en_o, 1);
        @(negedge clk);
        check(clk_en_o == 1'b0, "R10 output single cycle wide", clk_en_o, 0);
    endtask

    task automatic t_ratio();
        int a_v [4] = '{2, 6, 5, 1};
        int b_v [4] = '{3, 6, 1, 4};
        int g;
        do_reset();
        src_pulse = 4'b0001;
        for (int i = 0; i < 4; i++) begin
            bus_wr(5'h04, 32'((b_v[i] << 3) | a_v[i]));
            wait_pulse(g);
            wait_pulse(g);
            check(g == a_v[i] * b_v[i], "R4 period equals product of divisors", g, a_v[i] * b_v[i]);
        end
    endtask

    task automatic t_zero();
        int c;
        int g;
        do_reset();
        src_pulse = 4'b0001;
        check(div_err_o == 1'b0, "R5 error clear before bad code", div_err_o, 0);
        bus_wr(5'h04, 32'h0F);
        count_pulses(40, c);
        check(c == 0, "R5 first-stage code 7 gives no pulses", c, 0);
        check(div_err_o == 1'b1, "R5 error raised by code 7", div_err_o, 1);
        bus_wr(5'h04, 32'h09);
        wait_pulse(g);
        check(g != -1, "R5 pulses resume after valid code", g, 1);
        check(div_err_o == 1'b1, "R5 error stays set", div_err_o, 1);
        do_reset();
        src_pulse = 4'b0001;
        bus_wr(5'h04, 32'h02);
        count_pulses(40, c);
        check(c == 0, "R5 second-stage code 0 gives no pulses", c, 0);
        check(div_err_o == 1'b1, "R5 error raised by code 0", div_err_o, 1);
    endtask

    task automatic t_gate();
        int c;
        do_reset();
        src_pulse = 4'b0001;
        bus_wr(5'h14, 32'h1);
        count_pulses(30, c);
        check(c == 0, "R6 disable bit blocks output", c, 0);
        bus_wr(5'h14, 32'hFFFF_FFFE);
        count_pulses(30, c);
        check(c == 30, "R6 clear disable bit passes pulses", c, 30);
    endtask

    task automatic t_csel();
        int c;
        do_reset();
        src_pulse = 4'b1111;
        bus_wr(5'h10, 32'h0);
        c = 0;
        repeat (20) begin
            @(negedge clk);
            if (clk_en_o) c++;
            xtal_pulse = ~xtal_pulse;
        end
        check(c == 10, "R7 bypass follows crystal pulses", c, 10);
        xtal_pulse = 1'b0;
        @(negedge clk);
        count_pulses(20, c);
        check(c == 0, "R7 source ignored in bypass", c, 0);
        src_pulse = 4'b0000;
        xtal_pulse = 1'b1;
        bus_wr(5'h10, 32'h1);
        count_pulses(20, c);
        check(c == 0, "R7 crystal ignored on divided path", c, 0);
    endtask

    task automatic t_retime();
        int g;
        do_reset();
        src_pulse = 4'b0001;
        bus_wr(5'h04, 32'h0C);
        wait_pulse(g);
        wait_pulse(g);
        check(g == 4, "R8 steady old period", g, 4);
        bus_wr(5'h04, 32'h0E);
        wait_pulse(g);
        check(g == 2, "R8 period in progress keeps old divisor", g, 2);
        wait_pulse(g);
        check(g == 6, "R8 new divisor after terminal count", g, 6);
    endtask

    task automatic t_restore();
        logic [31:0] saved [6] = '{32'h3, 32'h1A, 32'h111, 32'h222, 32'h1, 32'h1};
        logic [31:0] other [6] = '{32'h1, 32'h09, 32'hAAA, 32'hBBB, 32'h0, 32'h0};
        logic [31:0] d;
        int low;
        int pc;
        do_reset();
        src_pulse = 4'b1111;
        xtal_pulse = 1'b1;
        for (int i = 0; i < 6; i++) bus_wr(5'(i * 4), saved[i]);
        @(negedge clk);
        save_req = 1'b1;
        @(negedge clk);
        save_req = 1'b0;
        for (int i = 0; i < 6; i++) bus_wr(5'(i * 4), other[i]);
        @(negedge clk);
        restore_req = 1'b1;
        @(negedge clk);
        restore_req = 1'b0;
        low = 0;
        pc = 0;
        while (!req_ready && low < 20) begin
            low++;
            if (clk_en_o) pc++;
            @(negedge clk);
        end
        check(low == 6, "R9 port busy for six cycles", low, 6);
        check(pc == 2, "R9 disable restored first", pc, 2);
        for (int i = 0; i < 6; i++) begin
            bus_rd(5'(i * 4), d);
            check(d == saved[i], "R9 restored register value", d, saved[i]);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_bus();
        t_select();
        t_ratio();
        t_zero();
        t_gate();
        t_csel();
        t_retime();
        t_restore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule